// File: doc/BRIEF.md
# Cross-Clock Video Memory Write Port

This block lets a processor running on its own clock post writes into video memory that belongs to a display engine on a separate pixel clock. The processor never waits on the memory. It loads a 16-bit target address and a 16-bit data value into two holding registers. It then writes the control register, which packs the pair into one 32-bit word and pushes it into a dual-clock queue.

On the pixel side, a drain stage takes one word at a time, but only in cycles where the renderer has not flagged the memory port as busy. It splits the word back into an address and a data value and raises a one-cycle write strobe. The queue is 16 words deep. Its pointers cross between the two clock domains as gray code through two-flop synchronizers. Reading the control register reports whether the queue is full and whether a posted write has ever been lost. Software uses these flags to throttle itself. In normal use this rarely matters, because the pixel clock runs at roughly twice the processor clock.

Top module: `vram_post_port`

## Requirements
- R1: Register selector 0 holds the 16-bit address and selector 1 holds the 16-bit data. A processor write to either selector stores the value, and a read of that selector returns the stored value.
- R2: A processor write to selector 2 (control) while the queue is not full enqueues one word, with the address in bits [31:16] and the data in bits [15:0]. The value written to the control register is ignored.
- R3: A read of selector 2 returns the full flag in bit 0. The flag is 1 when the queue holds 16 unread words and 0 otherwise.
- R4: A control write while the queue is full is dropped. Bit 1 of the control read then becomes 1 and stays 1 until the processor-side reset.
- R5: Words reach video memory in the order they were enqueued, with none lost or duplicated. When the queue is empty, no strobe is issued.
- R6: No word is taken from the queue in a pixel cycle where the busy input is high. The write strobe is never high in the cycle after the busy input was high.
- R7: Each dequeue drives the address and data on the memory outputs for exactly one pixel-clock cycle with the write strobe high. The outputs appear one pixel cycle after the dequeue.
- R8: The write pointer and the read pointer are gray coded and change by at most one bit per clock.
- R9: After reset the write strobe is 0 and the processor reads 0 from all three selectors.
- R10: The queue holds exactly 16 words. After 15 posted words with no draining, the full flag is still 0. The 16th word sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock |
| cpu_rst_n | input | 1 | Processor-side active-low reset |
| cpu_wr | input | 1 | Processor write enable |
| cpu_sel | input | 2 | Register selector: 0 address, 1 data, 2 control |
| cpu_wdata | input | 16 | Processor write value |
| cpu_rdata | output | 16 | Value of the selected register |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Pixel-side active-low reset |
| vram_busy | input | 1 | Renderer is using video memory this cycle |
| vram_addr | output | 16 | Video memory write address |
| vram_wdata | output | 16 | Video memory write data |
| vram_we | output | 1 | One-cycle video memory write strobe |

## Verification
Random address and data pairs are posted with random gaps while the busy input toggles randomly at a low rate. This checks ordering and packing across the clock ratio, and checks that no strobe follows a busy cycle. A directed pass then holds busy high and posts 15, 16 and 17 words. This separates the exact depth, the moment the full flag rises, and the dropping of the overflow word with its sticky flag. It also confirms that nothing is lost or reordered once busy is released. Register readback and the reset values are checked separately, so that they are not confused with queue behaviour.

// File: rtl/vpp_pkg.sv
package vpp_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    function automatic logic [7:0] to_gray(input logic [7:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/vpp_sync2.sv
module vpp_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] out_q, out_d;

    always_comb begin
        meta_d = din;
        out_d  = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            out_q  <= '0;
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/vpp_cpu_regs.sv
module vpp_cpu_regs #(
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int WW = AW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [1:0]    sel,
    input  logic [15:0]   wdata,
    input  logic          full,
    output logic [15:0]   rdata,
    output logic          push,
    output logic [WW-1:0] push_word,
    output logic          ovf
);
    import vpp_pkg::*;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          ovf;
    } regs_t;

    regs_t r_q, r_d;
    logic  ctrl_wr;

    always_comb begin
        r_d     = r_q;
        ctrl_wr = wr && (reg_sel_e'(sel) == SEL_CTRL);
        if (wr && reg_sel_e'(sel) == SEL_ADDR) r_d.addr = wdata[AW-1:0];
        if (wr && reg_sel_e'(sel) == SEL_DATA) r_d.data = wdata[DW-1:0];
        if (ctrl_wr && full) r_d.ovf = 1'b1;
        push      = ctrl_wr && !full;
        push_word = {r_q.addr, r_q.data};
        unique case (reg_sel_e'(sel))
            SEL_ADDR: rdata = 16'(r_q.addr);
            SEL_DATA: rdata = 16'(r_q.data);
            SEL_CTRL: rdata = {14'd0, r_q.ovf, full};
            default:  rdata = 16'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ovf = r_q.ovf;
endmodule

// File: rtl/vpp_wr_side.sv
module vpp_wr_side #(
    parameter int PW = 4,
    localparam int GW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [GW-1:0] rgray_sync,
    output logic [PW-1:0] waddr,
    output logic [GW-1:0] wgray,
    output logic          full
);
    import vpp_pkg::*;

    typedef struct packed {
        logic [GW-1:0] bin;
        logic [GW-1:0] gray;
    } ptr_t;

    ptr_t p_q, p_d;
    logic [GW-1:0] bin_nx;

    always_comb begin
        full   = (p_q.gray == {~rgray_sync[GW-1:GW-2], rgray_sync[GW-3:0]});
        bin_nx = p_q.bin + GW'(push && !full);
        p_d.bin  = bin_nx;
        p_d.gray = GW'(to_gray(8'(bin_nx)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign waddr = p_q.bin[PW-1:0];
    assign wgray = p_q.gray;
endmodule

// File: rtl/vpp_rd_side.sv
module vpp_rd_side #(
    parameter int PW = 4,
    localparam int GW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic [GW-1:0] wgray_sync,
    output logic [PW-1:0] raddr,
    output logic [GW-1:0] rgray,
    output logic          empty,
    output logic          pop
);
    import vpp_pkg::*;

    typedef struct packed {
        logic [GW-1:0] bin;
        logic [GW-1:0] gray;
    } ptr_t;

    ptr_t p_q, p_d;
    logic [GW-1:0] bin_nx;

    always_comb begin
        empty  = (p_q.gray == wgray_sync);
        pop    = !empty && !busy;
        bin_nx = p_q.bin + GW'(pop);
        p_d.bin  = bin_nx;
        p_d.gray = GW'(to_gray(8'(bin_nx)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign raddr = p_q.bin[PW-1:0];
    assign rgray = p_q.gray;
endmodule

// File: rtl/vpp_drain.sv
module vpp_drain #(
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int WW = AW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [WW-1:0] word,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          we
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          we;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d    = o_q;
        o_d.we = pop;
        if (pop) begin
            o_d.addr = word[WW-1:DW];
            o_d.data = word[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign addr = o_q.addr;
    assign data = o_q.data;
    assign we   = o_q.we;
endmodule

// File: rtl/vram_post_port.sv
module vram_post_port #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int PW = 4,
    localparam int WW    = AW + DW,
    localparam int GW    = PW + 1,
    localparam int DEPTH = 1 << PW
) (
    input  logic          cpu_clk,
    input  logic          cpu_rst_n,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_sel,
    input  logic [15:0]   cpu_wdata,
    output logic [15:0]   cpu_rdata,
    input  logic          pix_clk,
    input  logic          pix_rst_n,
    input  logic          vram_busy,
    output logic [AW-1:0] vram_addr,
    output logic [DW-1:0] vram_wdata,
    output logic          vram_we
);
    logic          push, wr_full, ovf_flag, rd_empty, rd_pop;
    logic [WW-1:0] push_word;
    logic [PW-1:0] waddr, raddr;
    logic [GW-1:0] wr_gray, rd_gray, wr_gray_s, rd_gray_s;
    logic [WW-1:0] store_q [DEPTH];

    vpp_cpu_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .wr(cpu_wr), .sel(cpu_sel),
        .wdata(cpu_wdata), .full(wr_full), .rdata(cpu_rdata),
        .push(push), .push_word(push_word), .ovf(ovf_flag)
    );

    vpp_wr_side #(.PW(PW)) u_wr (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .push(push),
        .rgray_sync(rd_gray_s), .waddr(waddr), .wgray(wr_gray), .full(wr_full)
    );

    vpp_sync2 #(.W(GW)) u_sync_r2w (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .din(rd_gray), .dout(rd_gray_s)
    );

    vpp_sync2 #(.W(GW)) u_sync_w2r (
        .clk(pix_clk), .rst_n(pix_rst_n), .din(wr_gray), .dout(wr_gray_s)
    );

    always_ff @(posedge cpu_clk) begin
        if (push) store_q[waddr] <= push_word;
    end

    vpp_rd_side #(.PW(PW)) u_rd (
        .clk(pix_clk), .rst_n(pix_rst_n), .busy(vram_busy),
        .wgray_sync(wr_gray_s), .raddr(raddr), .rgray(rd_gray),
        .empty(rd_empty), .pop(rd_pop)
    );

    vpp_drain #(.AW(AW), .DW(DW)) u_drain (
        .clk(pix_clk), .rst_n(pix_rst_n), .pop(rd_pop), .word(store_q[raddr]),
        .addr(vram_addr), .data(vram_wdata), .we(vram_we)
    );
endmodule

// File: rtl/vpp_checker.sv
module vpp_checker #(
    parameter int GW = 5
) (
    input logic          cpu_clk,
    input logic          cpu_rst_n,
    input logic          pix_clk,
    input logic          pix_rst_n,
    input logic          cpu_wr,
    input logic [1:0]    cpu_sel,
    input logic          wr_full,
    input logic          ovf_flag,
    input logic [GW-1:0] wr_gray,
    input logic [GW-1:0] rd_gray,
    input logic          rd_empty,
    input logic          vram_busy,
    input logic          vram_we
);
    assert_push_advance_R2: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (cpu_wr && cpu_sel == 2'd2 && !wr_full) |=> !$stable(wr_gray));

    assert_drop_when_full_R4: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (cpu_wr && cpu_sel == 2'd2 && wr_full) |=> (ovf_flag && $stable(wr_gray)));

    assert_ovf_sticky_R4: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        ovf_flag |=> ovf_flag);

    assert_empty_no_strobe_R5: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        rd_empty |=> !vram_we);

    assert_no_pop_busy_R6: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        vram_busy |=> !vram_we);

    assert_wgray_step_R8: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        $onehot0(wr_gray ^ $past(wr_gray)));

    assert_rgray_step_R8: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        $onehot0(rd_gray ^ $past(rd_gray)));
endmodule

bind vram_post_port vpp_checker #(.GW(GW)) u_chk (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
    .cpu_wr(cpu_wr), .cpu_sel(cpu_sel), .wr_full(wr_full), .ovf_flag(ovf_flag),
    .wr_gray(wr_gray), .rd_gray(rd_gray), .rd_empty(rd_empty),
    .vram_busy(vram_busy), .vram_we(vram_we)
);

// File: tb/vram_post_port_tb.sv
`timescale 1ns/1ps
module vram_post_port_tb;
    logic        cpu_clk = 0, cpu_rst_n = 0, cpu_wr = 0;
    logic [1:0]  cpu_sel = 0;
    logic [15:0] cpu_wdata = 0, cpu_rdata;
    logic        pix_clk = 0, pix_rst_n = 0, vram_busy = 0;
    logic [15:0] vram_addr, vram_wdata;
    logic        vram_we;

    int unsigned total = 0, bad = 0;
    int          busy_mode = 0;
    logic        busy_prev = 0;
    logic [31:0] exp_q [$];
    bit          done = 0;

    always #5 cpu_clk = ~cpu_clk;
    always #2.1 pix_clk = ~pix_clk;

    vram_post_port u_dut (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pix_clk(pix_clk),
        .pix_rst_n(pix_rst_n), .vram_busy(vram_busy), .vram_addr(vram_addr),
        .vram_wdata(vram_wdata), .vram_we(vram_we)
    );

    function automatic logic [31:0] pack_word(input logic [15:0] a, input logic [15:0] d);
        return {a, d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge pix_clk) begin
        #1;
        case (busy_mode)
            1:       vram_busy = ($urandom % 4) == 0;
            2:       vram_busy = 1'b1;
            default: vram_busy = 1'b0;
        endcase
    end

    always @(negedge pix_clk) begin
        if (pix_rst_n && vram_we) begin
            check("R6 strobe after busy", {31'd0, busy_prev}, 32'd0);
            if (exp_q.size() == 0) begin
                check("R5 unexpected strobe", pack_word(vram_addr, vram_wdata), 32'hxxxxxxxx);
            end else begin
                check("R7 R2 word at memory port", pack_word(vram_addr, vram_wdata), exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
        busy_prev = vram_busy;
    end

    task automatic reg_write(input logic [1:0] s, input logic [15:0] v);
        @(negedge cpu_clk);
        cpu_wr = 1; cpu_sel = s; cpu_wdata = v;
        @(negedge cpu_clk);
        cpu_wr = 0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [15:0] v);
        @(negedge cpu_clk);
        cpu_wr = 0; cpu_sel = s;
        #1 v = cpu_rdata;
    endtask

    task automatic post(input logic [15:0] a, input logic [15:0] d, output logic was_full);
        reg_write(2'd0, a);
        reg_write(2'd1, d);
        @(negedge cpu_clk);
        cpu_sel = 2'd2; cpu_wdata = $urandom;
        #1 was_full = cpu_rdata[0];
        cpu_wr = 1;
        if (!was_full) exp_q.push_back(pack_word(a, d));
        @(negedge cpu_clk);
        cpu_wr = 0;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        logic        f;
        void'($urandom(32'h5eed_0042));
        #23;
        cpu_rst_n = 1; pix_rst_n = 1;

        reg_read(2'd0, v); check("R9 reset addr reg", 32'(v), 0);
        reg_read(2'd1, v); check("R9 reset data reg", 32'(v), 0);
        reg_read(2'd2, v); check("R9 reset status", 32'(v), 0);
        check("R9 reset strobe", 32'(vram_we), 0);

        reg_write(2'd0, 16'hBEEF);
        reg_write(2'd1, 16'h1234);
        reg_read(2'd0, v); check("R1 addr readback", 32'(v), 32'h0000BEEF);
        reg_read(2'd1, v); check("R1 data readback", 32'(v), 32'h00001234);

        post(16'h0001, 16'hAAAA, f);
        post(16'hFFFF, 16'h0000, f);
        repeat (20) @(negedge cpu_clk);
        check("R5 directed drained", exp_q.size(), 0);

        busy_mode = 1;
        for (int i = 0; i < 200; i++) begin
            post(16'($urandom), 16'($urandom), f);
            repeat ($urandom % 4) @(negedge cpu_clk);
        end
        busy_mode = 0;
        repeat (40) @(negedge cpu_clk);
        check("R5 random drained", exp_q.size(), 0);

        busy_mode = 2;
        repeat (10) @(negedge cpu_clk);
        for (int i = 0; i < 15; i++) post(16'(16'h4000 + i), 16'(i * 3), f);
        reg_read(2'd2, v); check("R10 not full after 15", 32'(v[0]), 0);
        post(16'h400F, 16'h002D, f);
        reg_read(2'd2, v); check("R3 full after 16", 32'(v[0]), 1);
        check("R4 no overflow yet", 32'(v[1]), 0);
        post(16'h7777, 16'h7777, f);
        check("R4 drop seen full", 32'(f), 1);
        reg_read(2'd2, v); check("R4 overflow flag set", 32'(v[1]), 1);
        check("R6 no strobe while busy", exp_q.size(), 16);

        busy_mode = 0;
        repeat (40) @(negedge cpu_clk);
        check("R5 full drain in order", exp_q.size(), 0);
        reg_read(2'd2, v);
        check("R3 full clears", 32'(v[0]), 0);
        check("R4 overflow sticky", 32'(v[1]), 1);

        done = 1;
        finish_run();
    end
endmodule